// File: doc/BRIEF.md
# Fan Tachometer Period Meter

This block times the gap between chosen transitions of a fan speed-sense signal. The signal is taken from a pin or, in loopback, from an internal PWM output. It is brought into the clock domain by a two-flop synchroniser and cleaned by a debounce filter whose length is set by a code. A transition detector then picks falling edges, rising edges or both. Between two picked edges a counter accumulates ticks of a prescaled clock, where the prescale ratio is four to the power of an exponent.

At each picked edge after the first, the tick count is loaded into a result register. A one-cycle update pulse is raised and counting starts again from zero. A full-measurement flag tells whether the result covers a complete interval: it is cleared when the counter saturates. A sticky interrupt flag records a captured value that is above a limit, or below it when the comparison is inverted. Software reads these outputs and converts the period to a speed elsewhere.

Top module: `tach_period_meter`

## Requirements
- R1: With `loopback_i` high the measured signal is `pwm_fb_i` and `tach_i` has no effect. With it low the measured signal is `tach_i`.
- R2: `raw_level_o` is the measured signal delayed by two clock edges through a synchroniser.
- R3: The debounced level takes a new synchronised level only after that level has been seen on L+1 consecutive clocks, where L = 3 - `deb_code_i` (code 0 gives 3, code 3 gives 0). A shorter excursion leaves `deb_level_o` unchanged.
- R4: `edge_code_i` picks the interval: 0 measures from a falling debounced edge to the next falling edge, 1 from rising to rising, and 2 or 3 from any edge to the next edge of either kind.
- R5: The tick period is 4^n clocks, with n = `div_exp_i` and values above 11 treated as 11. A captured interval of D clocks yields floor(D / 4^n).
- R6: The first picked edge after enable only starts counting. Every later picked edge loads `period_o`, pulses `period_upd_o` for one cycle and restarts the count at zero.
- R7: The counter stops at its all-ones value. Reaching that value clears `full_meas_o`, and a capture of the all-ones value leaves it cleared.
- R8: A capture below the all-ones value sets `full_meas_o`. The flag is 0 after reset.
- R9: On a capture, `irq_o` is set if `irq_en_i` is high and the value is above `limit_i`, or below it when `limit_inv_i` is high. With `irq_en_i` low it is not set.
- R10: `irq_o` stays set until `irq_clr_i` is high at a clock edge. A new setting condition in the same cycle wins over the clear.
- R11: While `enable_i` is low the count, the arming state and `full_meas_o` are cleared, and `period_o` keeps its last value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| enable_i | input | 1 | Measurement enable |
| loopback_i | input | 1 | Select internal PWM feedback instead of the pin |
| tach_i | input | 1 | Tachometer pin |
| pwm_fb_i | input | 1 | Internal PWM output for loopback |
| deb_code_i | input | 2 | Debounce length code |
| edge_code_i | input | 2 | Edge selection code |
| div_exp_i | input | EXP_W | Prescale exponent n (ratio 4^n) |
| limit_i | input | CNT_W | Interrupt limit |
| limit_inv_i | input | 1 | Invert the limit comparison |
| irq_en_i | input | 1 | Interrupt enable |
| irq_clr_i | input | 1 | Clear strobe for the interrupt flag |
| period_o | output | CNT_W | Last captured tick count |
| period_upd_o | output | 1 | One-cycle pulse on each capture |
| full_meas_o | output | 1 | Result covers a complete interval |
| raw_level_o | output | 1 | Synchronised input level |
| deb_level_o | output | 1 | Debounced input level |
| irq_o | output | 1 | Interrupt status |

## Verification
The bench aims at glitches just shorter than the debounce length. A filter that is off by one would let them through and produce extra captures. It checks that the first edge after enable does not capture: a design that captures it would report a bogus short or stale period and an extra update pulse. A quiet interval long enough to saturate the counter must clear the full flag and give the all-ones value. A design that wraps would report a small period as valid. Exponents above the clamp, the inverted limit and a disabled interrupt are each driven, because a wrong prescale or a wrong comparison direction shows up directly in the result and interrupt flag.

// File: rtl/tach_pkg.sv
package tach_pkg;
  typedef enum logic [1:0] {
    EDGE_FALL  = 2'd0,
    EDGE_RISE  = 2'd1,
    EDGE_ANY   = 2'd2,
    EDGE_ANY_B = 2'd3
  } edge_mode_e;

  // filter length from code: 0->3, 1->2, 2->1, 3->0
  function automatic logic [1:0] deb_len(input logic [1:0] code);
    return 2'd3 - code;
  endfunction
endpackage

// File: rtl/tach_debounce.sv
module tach_debounce (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       in_i,
  input  logic [1:0] code_i,
  output logic       raw_o,
  output logic       deb_o
);
  import tach_pkg::*;

  logic [1:0] sync_q;
  logic       deb_q;
  logic [1:0] hold_q;
  logic [1:0] len;

  assign len = deb_len(code_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      deb_q  <= 1'b0;
      hold_q <= '0;
    end else begin
      sync_q <= {sync_q[0], in_i};
      if (sync_q[1] == deb_q) begin
        hold_q <= '0;
      end else if (hold_q >= len) begin
        deb_q  <= sync_q[1];
        hold_q <= '0;
      end else begin
        hold_q <= hold_q + 2'd1;
      end
    end
  end

  assign raw_o = sync_q[1];
  assign deb_o = deb_q;

  assert_deb_follow_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (deb_q != $past(deb_q)) |-> (deb_q == $past(sync_q[1])));
  assert_deb_code3_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (code_i == 2'd3 && sync_q[1] != deb_q) |=> (deb_q == $past(sync_q[1])));
endmodule

// File: rtl/tach_prescaler.sv
module tach_prescaler #(
  parameter int EXP_W   = 4,
  parameter int MAX_EXP = 11
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             restart_i,
  input  logic [EXP_W-1:0] exp_i,
  output logic             tick_o
);
  localparam int PRE_W = 2 * MAX_EXP;

  logic [PRE_W-1:0] pre_q;
  logic [PRE_W-1:0] limit;
  logic [EXP_W-1:0] exp_eff;

  assign exp_eff = (exp_i > EXP_W'(MAX_EXP)) ? EXP_W'(MAX_EXP) : exp_i;

  // limit = 4^n - 1 : low 2n bits set
  always_comb begin
    for (int i = 0; i < PRE_W; i++) limit[i] = (i < 2 * int'(exp_eff));
  end

  assign tick_o = run_i && (pre_q >= limit);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  pre_q <= '0;
    else if (!run_i || restart_i) pre_q <= '0;
    else if (tick_o)              pre_q <= '0;
    else                          pre_q <= pre_q + PRE_W'(1);
  end

  assert_div1_every_clk_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && exp_eff == '0) |-> tick_o);
  assert_idle_no_tick_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |-> !tick_o);
endmodule

// File: rtl/tach_interval_counter.sv
module tach_interval_counter #(
  parameter int CNT_W = 20
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             enable_i,
  input  logic             edge_i,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] limit_i,
  input  logic             limit_inv_i,
  input  logic             irq_en_i,
  input  logic             irq_clr_i,
  output logic [CNT_W-1:0] result_o,
  output logic             upd_o,
  output logic             full_o,
  output logic             irq_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt_q, res_q, cap_val;
  logic             armed_q, upd_q, full_q, irq_q;
  logic             capture, hit;

  assign cap_val = (tick_i && cnt_q != CNT_MAX) ? cnt_q + CNT_W'(1) : cnt_q;
  assign capture = enable_i && edge_i && armed_q;
  assign hit     = limit_inv_i ? (cap_val < limit_i) : (cap_val > limit_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      res_q   <= '0;
      armed_q <= 1'b0;
      upd_q   <= 1'b0;
      full_q  <= 1'b0;
    end else begin
      upd_q <= 1'b0;
      if (!enable_i) begin
        cnt_q   <= '0;
        armed_q <= 1'b0;
        full_q  <= 1'b0;
      end else if (edge_i) begin
        if (armed_q) begin
          res_q  <= cap_val;
          upd_q  <= 1'b1;
          full_q <= (cap_val != CNT_MAX);
        end
        cnt_q   <= '0;
        armed_q <= 1'b1;
      end else if (tick_i && cnt_q != CNT_MAX) begin
        cnt_q <= cnt_q + CNT_W'(1);
        if (cnt_q + CNT_W'(1) == CNT_MAX) full_q <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                       irq_q <= 1'b0;
    else if (capture && irq_en_i && hit) irq_q <= 1'b1;
    else if (irq_clr_i)                irq_q <= 1'b0;
  end

  assign result_o = res_q;
  assign upd_o    = upd_q;
  assign full_o   = full_q;
  assign irq_o    = irq_q;

  assert_sat_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (enable_i && !edge_i && cnt_q == CNT_MAX) |=> (cnt_q == CNT_MAX));
  assert_sat_not_full_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (enable_i && armed_q && cnt_q == CNT_MAX) |-> !full_q);
  assert_full_matches_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_q |-> (full_q == (res_q != CNT_MAX)));
  assert_disable_clear_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !enable_i |=> (cnt_q == '0 && !full_q && !upd_q));
  assert_irq_gate_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_q) |-> ($past(irq_en_i) && upd_q));
  assert_irq_clear_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_clr_i && !capture) |=> !irq_q);
endmodule

// File: rtl/tach_period_meter.sv
module tach_period_meter #(
  parameter int CNT_W   = 20,
  parameter int EXP_W   = 4,
  parameter int MAX_EXP = 11
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             enable_i,
  input  logic             loopback_i,
  input  logic             tach_i,
  input  logic             pwm_fb_i,
  input  logic [1:0]       deb_code_i,
  input  logic [1:0]       edge_code_i,
  input  logic [EXP_W-1:0] div_exp_i,
  input  logic [CNT_W-1:0] limit_i,
  input  logic             limit_inv_i,
  input  logic             irq_en_i,
  input  logic             irq_clr_i,
  output logic [CNT_W-1:0] period_o,
  output logic             period_upd_o,
  output logic             full_meas_o,
  output logic             raw_level_o,
  output logic             deb_level_o,
  output logic             irq_o
);
  import tach_pkg::*;

  logic src, deb_prev_q, rise, fall, sel_edge, tick;

  assign src = loopback_i ? pwm_fb_i : tach_i;

  tach_debounce u_deb (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .in_i   (src),
    .code_i (deb_code_i),
    .raw_o  (raw_level_o),
    .deb_o  (deb_level_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) deb_prev_q <= 1'b0;
    else         deb_prev_q <= deb_level_o;
  end

  assign rise = deb_level_o & ~deb_prev_q;
  assign fall = ~deb_level_o & deb_prev_q;

  always_comb begin
    unique case (edge_mode_e'(edge_code_i))
      EDGE_FALL: sel_edge = fall;
      EDGE_RISE: sel_edge = rise;
      default:   sel_edge = rise | fall;
    endcase
  end

  tach_prescaler #(.EXP_W(EXP_W), .MAX_EXP(MAX_EXP)) u_pre (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .run_i     (enable_i),
    .restart_i (sel_edge),
    .exp_i     (div_exp_i),
    .tick_o    (tick)
  );

  tach_interval_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .enable_i    (enable_i),
    .edge_i      (sel_edge),
    .tick_i      (tick),
    .limit_i     (limit_i),
    .limit_inv_i (limit_inv_i),
    .irq_en_i    (irq_en_i),
    .irq_clr_i   (irq_clr_i),
    .result_o    (period_o),
    .upd_o       (period_upd_o),
    .full_o      (full_meas_o),
    .irq_o       (irq_o)
  );

  assert_upd_after_edge_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    period_upd_o |-> ($past(sel_edge) && $past(enable_i)));
  assert_fall_mode_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (edge_code_i == 2'd0 && period_upd_o && $past(edge_code_i) == 2'd0) |-> !$past(deb_level_o));
endmodule

// File: tb/tach_period_meter_test.sv
module tach_period_meter_test;
  localparam int CW   = 12;
  localparam int MAXV = (1 << CW) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0, lb = 1'b0, pin = 1'b0, pwm = 1'b0;
  logic [1:0] dcode = 2'd0, ecode = 2'd0;
  logic [3:0] dexp = 4'd0;
  logic [CW-1:0] thr = MAXV[CW-1:0];
  logic inv = 1'b0, ien = 1'b0, iclr = 1'b0;
  logic [CW-1:0] per;
  logic upd, full, raw, deb, irq;

  int checks = 0, fails = 0, cyc = 0, upd_seen = 0;
  bit done = 1'b0, deb_high_seen = 1'b0;

  always #10 clk = ~clk; // 50 MHz

  tach_period_meter #(.CNT_W(CW)) uut (
    .clk_i(clk), .rst_ni(rst_n), .enable_i(en), .loopback_i(lb), .tach_i(pin),
    .pwm_fb_i(pwm), .deb_code_i(dcode), .edge_code_i(ecode), .div_exp_i(dexp),
    .limit_i(thr), .limit_inv_i(inv), .irq_en_i(ien), .irq_clr_i(iclr),
    .period_o(per), .period_upd_o(upd), .full_meas_o(full), .raw_level_o(raw),
    .deb_level_o(deb), .irq_o(irq)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // behavioural reference model
  int m_s1, m_s2, m_deb, m_hold, m_prev, m_pre, m_cnt, m_armed, m_res, m_upd, m_full, m_irq;
  always @(posedge clk or negedge rst_n) begin : model
    int in_v, len, e, dv, tk, rs, fl, eg, cap, hit;
    if (!rst_n) begin
      m_s1 = 0; m_s2 = 0; m_deb = 0; m_hold = 0; m_prev = 0; m_pre = 0;
      m_cnt = 0; m_armed = 0; m_res = 0; m_upd = 0; m_full = 0; m_irq = 0;
    end else begin
      in_v = lb ? int'(pwm) : int'(pin);
      rs = (m_deb == 1 && m_prev == 0);
      fl = (m_deb == 0 && m_prev == 1);
      eg = (ecode == 0) ? fl : (ecode == 1) ? rs : (rs || fl);
      e  = (dexp > 11) ? 11 : int'(dexp);
      dv = 1 << (2 * e);
      tk = en && (m_pre >= dv - 1);
      cap = (tk && m_cnt != MAXV) ? m_cnt + 1 : m_cnt;
      hit = inv ? (cap < int'(thr)) : (cap > int'(thr));
      if (en && eg && m_armed && ien && hit) m_irq = 1;
      else if (iclr) m_irq = 0;
      m_upd = 0;
      if (!en) begin
        m_cnt = 0; m_armed = 0; m_full = 0;
      end else if (eg) begin
        if (m_armed) begin m_res = cap; m_upd = 1; m_full = (cap != MAXV); end
        m_cnt = 0; m_armed = 1;
      end else if (tk && m_cnt != MAXV) begin
        m_cnt++;
        if (m_cnt == MAXV) m_full = 0;
      end
      if (!en || eg || tk) m_pre = 0; else m_pre++;
      m_prev = m_deb;
      len = 3 - int'(dcode);
      if (m_s2 == m_deb) m_hold = 0;
      else if (m_hold >= len) begin m_deb = m_s2; m_hold = 0; end
      else m_hold++;
      m_s2 = m_s1;
      m_s1 = in_v;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R6 period", int'(per), m_res);
      chk("R6 update", int'(upd), m_upd);
      chk("R8 full", int'(full), m_full);
      chk("R9 irq", int'(irq), m_irq);
      chk("R2 raw", int'(raw), m_s2);
      chk("R3 deb", int'(deb), m_deb);
      if (upd) upd_seen++;
      if (deb) deb_high_seen = 1'b1;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      done = 1'b1;
      fails++;
      $display("FAIL watchdog actual=%0d expected=<150000", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wave(input int hi, input int lo, input int n, input bit to_pwm);
    for (int i = 0; i < n; i++) begin
      if (to_pwm) pwm = 1'b1; else pin = 1'b1;
      idle(hi);
      if (to_pwm) pwm = 1'b0; else pin = 1'b0;
      idle(lo);
    end
  endtask

  task automatic pulse_clr();
    iclr = 1'b1; idle(1); iclr = 1'b0;
  endtask

  int keep;
  initial begin
    idle(3);
    chk("R8 reset full", int'(full), 0);
    chk("R6 reset period", int'(per), 0);
    chk("R9 reset irq", int'(irq), 0);
    rst_n = 1'b1;
    idle(2);
    en = 1'b1; ien = 1'b1;
    // R2: two-edge synchroniser delay
    pin = 1'b1; idle(1);
    chk("R2 raw after 1", int'(raw), 0);
    idle(1);
    chk("R2 raw after 2", int'(raw), 1);
    // R4 falling-to-falling, R6 capture
    wave(20, 20, 5, 1'b0); idle(12);
    chk("R4 fall-fall period", int'(per), 40);
    chk("R8 full after capture", int'(full), 1);
    // R4 rising-to-rising
    ecode = 2'd1;
    wave(15, 15, 4, 1'b0); idle(12);
    chk("R4 rise-rise period", int'(per), 30);
    // R4 any edge
    ecode = 2'd2;
    wave(12, 20, 4, 1'b0); idle(12);
    chk("R4 any-edge period", int'(per), 12);
    // R5 divider 4^1
    ecode = 2'd0; dexp = 4'd1;
    wave(20, 20, 4, 1'b0); idle(12);
    chk("R5 div4 period", int'(per), 10);
    // R5 exponent clamp
    dexp = 4'd13;
    wave(20, 20, 3, 1'b0); idle(12);
    chk("R5 clamp period", int'(per), 0);
    chk("R5 clamp full", int'(full), 1);
    dexp = 4'd0;
    wave(20, 20, 2, 1'b0); idle(12);
    // R3 short glitch ignored with code 0
    ecode = 2'd2; idle(8);
    keep = int'(per); deb_high_seen = 1'b0;
    pin = 1'b1; idle(3); pin = 1'b0; idle(12);
    chk("R3 glitch ignored deb", int'(deb_high_seen), 0);
    chk("R3 glitch ignored period", int'(per), keep);
    // R3 code 3 passes a single clock
    dcode = 2'd3; idle(4);
    pin = 1'b1; idle(1); pin = 1'b0; idle(12);
    chk("R3 code3 passes", int'(deb_high_seen), 1);
    dcode = 2'd1; ecode = 2'd0; idle(8);
    // R1 loopback, pin held low
    lb = 1'b1;
    wave(12, 12, 4, 1'b1); idle(12);
    chk("R1 loopback period", int'(per), 24);
    lb = 1'b0; idle(8);
    // R9 above limit
    thr = CW'(30); pulse_clr(); idle(4);
    wave(20, 20, 3, 1'b0); idle(12);
    chk("R9 above limit", int'(irq), 1);
    pulse_clr(); idle(1);
    chk("R10 cleared", int'(irq), 0);
    // R9 inverted
    inv = 1'b1;
    wave(20, 20, 3, 1'b0); idle(12);
    chk("R9 inverted no hit", int'(irq), 0);
    wave(10, 10, 3, 1'b0); idle(12);
    chk("R9 inverted hit", int'(irq), 1);
    pulse_clr(); idle(2);
    ien = 1'b0;
    wave(10, 10, 3, 1'b0); idle(12);
    chk("R9 disabled irq", int'(irq), 0);
    // R7 saturation
    inv = 1'b0; thr = MAXV[CW-1:0]; ien = 1'b1;
    wave(20, 20, 2, 1'b0); idle(12);
    chk("R8 full before sat", int'(full), 1);
    idle(4300);
    chk("R7 sat clears full", int'(full), 0);
    wave(10, 10, 1, 1'b0); idle(12);
    chk("R7 sat period", int'(per), MAXV);
    chk("R7 sat full", int'(full), 0);
    // R11 disable
    wave(20, 20, 2, 1'b0); idle(12);
    keep = int'(per);
    en = 1'b0; idle(3);
    chk("R11 full cleared", int'(full), 0);
    chk("R11 period kept", int'(per), keep);
    en = 1'b1; idle(2); upd_seen = 0;
    wave(10, 10, 2, 1'b0); idle(12);
    chk("R6 first edge arms only", upd_seen, 1);
    chk("R6 rearmed period", int'(per), 20);
    idle(4);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule